// File: doc/BRIEF.md
# Stream-Loaded Shadowed PWM Channel

This block drives one pulse-width-modulated output. All of its settings (tick count per period, active-tick count and clock-enable choice) arrive together as one packed 53-bit word on a valid-qualified routing input. The first word accepted after the channel is enabled starts the waveform at once. Each later word is parked in a shadow register and becomes active only at the next period boundary, so period, duty and clock choice always switch together, and no period is ever cut short or mixed.

The channel does not divide the clock itself. Its input is a vector of prescaled clock enables, and it picks one of them with the clock-select field. Its counter advances only on cycles where the chosen enable is high. The output is active while the count is below the duty value. The output frequency is therefore the selected tick rate divided by the period. For example, a 1 MHz tick with period 1000 gives 1 kHz, and duty 500 then gives a 50 % high time.

Top module: `pwm_stream_chan`

## Requirements
- R1: The incoming word is decoded as follows: bits 23:0 are the period, bits 47:24 are the duty, and bits 52:48 are the clock select.
- R2: Suppose the channel is enabled and not yet running. A valid word then loads the active settings at the next clock edge, with the counter at 0. The output reflects the new settings from that edge on.
- R3: While the channel runs, a valid word goes to the shadow register. The shadow moves to the active settings only at a period boundary, which is a selected tick with the counter at period-1. A word that arrives in the boundary cycle is applied at that boundary. When several words arrive before a boundary, the last one wins. Settings never change between boundaries.
- R4: The counter advances by one only on cycles where the selected tick enable is high. It holds on every other cycle and wraps from period-1 to 0.
- R5: The output is high while the channel runs with a nonzero period and the count is below the duty, and low otherwise. Each period therefore lasts `period` selected ticks, of which `duty` are high.
- R6: A duty of 0 keeps the output low. A duty greater than or equal to the period keeps the output high for the whole period.
- R7: A period of 0 stops the channel: the counter stays at 0 and the output is low. While stopped, a pending or arriving word is applied on the next selected tick.
- R8: A clock-select value greater than or equal to NUM_TICKS uses tick enable 0.
- R9: While en_i is low, the channel clears: it is not running, nothing is pending, and the output is low. Words are ignored while en_i is low. After en_i rises again, the first word is handled as a first load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable; low clears the channel |
| word_valid_i | input | 1 | Qualifies word_i for one cycle |
| word_i | input | 53 | Packed settings: period, duty, clock select |
| tick_en_i | input | NUM_TICKS | Prescaled clock enables, one per source |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The assertions take the tick enables to be single-cycle pulses that are already synchronous to clk_i. They also assume that word_valid_i is honoured in any cycle, including the boundary cycle and cycles with en_i low. The assertions assume NUM_TICKS does not exceed the range of the select field. The stimulus drives every input on the falling edge and keeps each enable periodic at rates of 1, 1/2, 1/3 and 1/4. It places words in the boundary cycle, back to back, with a zero period, with out-of-range selects and while disabled, so that each ordering case in the shadow path is reached.

// File: rtl/pwm_stream_pkg.sv
package pwm_stream_pkg;
  localparam int unsigned PER_W  = 24;
  localparam int unsigned DUTY_W = 24;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned WORD_W = PER_W + DUTY_W + SEL_W;
  localparam int unsigned CMP_W  = (PER_W > DUTY_W) ? PER_W : DUTY_W;

  typedef struct packed {
    logic [SEL_W-1:0]  clk_sel;
    logic [DUTY_W-1:0] duty;
    logic [PER_W-1:0]  period;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_word_unpack.sv
module pwm_word_unpack
  import pwm_stream_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output pwm_cfg_t          cfg_o
);
  localparam int unsigned DUTY_LSB = PER_W;
  localparam int unsigned SEL_LSB  = PER_W + DUTY_W;

  always_comb begin
    cfg_o.period  = word_i[PER_W-1:0];
    cfg_o.duty    = word_i[DUTY_LSB +: DUTY_W];
    cfg_o.clk_sel = word_i[SEL_LSB +: SEL_W];
  end
endmodule

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
  import pwm_stream_pkg::*;
#(
  parameter int unsigned NUM_TICKS = 4
) (
  input  logic [NUM_TICKS-1:0] tick_en_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 tick_o
);
  logic [NUM_TICKS-1:0] hit;
  logic                 in_range;

  for (genvar g = 0; g < NUM_TICKS; g++) begin : g_hit
    assign hit[g] = (sel_i == SEL_W'(g)) & tick_en_i[g];
  end

  assign in_range = ({1'b0, sel_i} < (SEL_W+1)'(NUM_TICKS));
  // out-of-range selects fall back to source 0
  assign tick_o   = in_range ? (|hit) : tick_en_i[0];
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_stream_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     valid_i,
  input  pwm_cfg_t cfg_i,
  input  logic     running_i,
  input  logic     boundary_i,
  output logic     load_o,
  output pwm_cfg_t load_cfg_o
);
  pwm_cfg_t shadow_q;
  logic     pending_q;
  logic     first_load;
  logic     bnd_load;

  assign first_load = en_i & valid_i & ~running_i;
  assign bnd_load   = en_i & boundary_i & (valid_i | pending_q);
  assign load_o     = first_load | bnd_load;
  // a word arriving in the load cycle bypasses the shadow
  assign load_cfg_o = valid_i ? cfg_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      pending_q <= 1'b0;
    end else if (!en_i) begin
      pending_q <= 1'b0;
    end else if (load_o) begin
      pending_q <= 1'b0;
    end else if (valid_i) begin
      shadow_q  <= cfg_i;
      pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_stream_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  pwm_cfg_t         load_cfg_i,
  input  logic             tick_i,
  output pwm_cfg_t         act_o,
  output logic [PER_W-1:0] cnt_o,
  output logic             running_o,
  output logic             boundary_o,
  output logic             pwm_o
);
  pwm_cfg_t         act_q;
  logic [PER_W-1:0] cnt_q;
  logic             run_q;
  logic             per_zero;
  logic             at_last;

  assign per_zero   = (act_q.period == '0);
  assign at_last    = (cnt_q == act_q.period - PER_W'(1));
  assign boundary_o = run_q & tick_i & (per_zero | at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en_i) begin
      act_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (load_i) begin
        act_q <= load_cfg_i;
        run_q <= 1'b1;
      end
      if (load_i || boundary_o) cnt_q <= '0;
      else if (run_q && tick_i && !per_zero) cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign pwm_o     = run_q & ~per_zero & (CMP_W'(cnt_q) < CMP_W'(act_q.duty));
  assign act_o     = act_q;
  assign cnt_o     = cnt_q;
  assign running_o = run_q;
endmodule

// File: rtl/pwm_stream_chan.sv
module pwm_stream_chan
  import pwm_stream_pkg::*;
#(
  parameter int unsigned NUM_TICKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 word_valid_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [NUM_TICKS-1:0] tick_en_i,
  output logic                 pwm_o
);
  pwm_cfg_t          in_cfg;
  pwm_cfg_t          load_cfg;
  pwm_cfg_t          act_cfg;
  logic              load;
  logic              sel_tick;
  logic              running;
  logic              boundary;
  logic [PER_W-1:0]  cnt;
  logic [PER_W-1:0]  act_period;
  logic [DUTY_W-1:0] act_duty;
  logic [SEL_W-1:0]  act_sel;

  pwm_word_unpack u_unpack (
    .word_i (word_i),
    .cfg_o  (in_cfg)
  );

  pwm_shadow u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .valid_i    (word_valid_i),
    .cfg_i      (in_cfg),
    .running_i  (running),
    .boundary_i (boundary),
    .load_o     (load),
    .load_cfg_o (load_cfg)
  );

  pwm_tick_sel #(.NUM_TICKS(NUM_TICKS)) u_tick_sel (
    .tick_en_i (tick_en_i),
    .sel_i     (act_sel),
    .tick_o    (sel_tick)
  );

  pwm_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .load_i     (load),
    .load_cfg_i (load_cfg),
    .tick_i     (sel_tick),
    .act_o      (act_cfg),
    .cnt_o      (cnt),
    .running_o  (running),
    .boundary_o (boundary),
    .pwm_o      (pwm_o)
  );

  assign act_period = act_cfg.period;
  assign act_duty   = act_cfg.duty;
  assign act_sel    = act_cfg.clk_sel;
endmodule

// File: rtl/pwm_stream_chan_chk.sv
module pwm_stream_chan_chk
  import pwm_stream_pkg::*;
#(
  parameter int unsigned NUM_TICKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic [NUM_TICKS-1:0] tick_en_i,
  input logic                 pwm_o,
  input logic                 sel_tick,
  input logic                 running,
  input logic [PER_W-1:0]     cnt,
  input logic [PER_W-1:0]     act_period,
  input logic [DUTY_W-1:0]    act_duty,
  input logic [SEL_W-1:0]     act_sel
);
  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && running && !sel_tick |=> $stable(cnt));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && running && sel_tick && act_period != '0 && cnt != act_period - PER_W'(1)
    |=> cnt == $past(cnt) + PER_W'(1));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && running && sel_tick && act_period != '0 && cnt == act_period - PER_W'(1)
    |=> cnt == '0);

  p_settings_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && running && !sel_tick
    |=> $stable(act_period) && $stable(act_duty) && $stable(act_sel));

  p_zero_duty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && act_duty == '0 |-> !pwm_o);

  p_full_duty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && act_period != '0 && CMP_W'(act_duty) >= CMP_W'(act_period) |-> pwm_o);

  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && act_period == '0 |-> !pwm_o && cnt == '0);

  p_fallback_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, act_sel} >= (SEL_W+1)'(NUM_TICKS) |-> sel_tick == tick_en_i[0]);
endmodule

bind pwm_stream_chan pwm_stream_chan_chk #(.NUM_TICKS(NUM_TICKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_en_i  (tick_en_i),
  .pwm_o      (pwm_o),
  .sel_tick   (sel_tick),
  .running    (running),
  .cnt        (cnt),
  .act_period (act_period),
  .act_duty   (act_duty),
  .act_sel    (act_sel)
);

// File: tb/pwm_stream_chan_tb.sv
module pwm_stream_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int MAX_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0;
  logic          vld = 1'b0;
  logic [52:0]   word = '0;
  logic [NT-1:0] tick = '0;
  logic          pwm;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R9";
  bit done = 0;

  pwm_stream_chan #(.NUM_TICKS(NT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .word_valid_i(vld),
    .word_i(word), .tick_en_i(tick), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick sources: rates 1, 1/2, 1/3, 1/4
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    tick[0] <= 1'b1;
    tick[1] <= ((tcnt + 1) % 2) == 0;
    tick[2] <= ((tcnt + 1) % 3) == 0;
    tick[3] <= ((tcnt + 1) % 4) == 0;
  end

  // behavioural reference
  longint m_per, m_duty, m_sel, m_cnt, s_per, s_duty, s_sel;
  bit m_run, m_pend;

  function automatic void take_word(input logic [52:0] w,
      output longint p, output longint d, output longint s);
    p = w[23:0]; d = w[47:24]; s = w[52:48];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_per = 0; m_duty = 0; m_sel = 0; m_cnt = 0; m_run = 0; m_pend = 0;
      s_per = 0; s_duty = 0; s_sel = 0;
    end else if (!en) begin
      m_per = 0; m_duty = 0; m_sel = 0; m_cnt = 0; m_run = 0; m_pend = 0;
    end else begin
      bit t, bnd;
      t = tick[(m_sel < NT) ? int'(m_sel) : 0];
      bnd = m_run && t && (m_per == 0 || m_cnt == m_per - 1);
      if (vld && !m_run) begin
        take_word(word, m_per, m_duty, m_sel); m_run = 1; m_cnt = 0;
      end else if (bnd) begin
        if (vld) take_word(word, m_per, m_duty, m_sel);
        else if (m_pend) begin m_per = s_per; m_duty = s_duty; m_sel = s_sel; end
        m_pend = 0; m_cnt = 0;
      end else begin
        if (vld) begin take_word(word, s_per, s_duty, s_sel); m_pend = 1; end
        if (m_run && t && m_per != 0) m_cnt++;
      end
    end
  end

  function automatic bit m_out();
    return m_run && m_per != 0 && m_cnt < m_duty;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_ni && !done) check(cur_req, pwm, m_out());

  function automatic logic [52:0] mk(input int p, input int d, input int s);
    return {s[4:0], d[23:0], p[23:0]};
  endfunction

  task automatic send(input logic [52:0] w);
    @(negedge clk); vld = 1'b1; word = w;
    @(negedge clk); vld = 1'b0; word = '0;
  endtask

  task automatic run_stats(input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0; prev = pwm;
    repeat (n) begin
      @(negedge clk);
      if (pwm) hi++;
      if (pwm && !prev) rises++;
      prev = pwm;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < MAX_CYC) begin @(posedge clk); cyc++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, MAX_CYC);
    finish_run();
  end

  initial begin
    int hi, rs;
    repeat (3) @(negedge clk);
    check("R9 reset", pwm, 0);
    rst_ni = 1'b1;
    // R9: word ignored while disabled
    cur_req = "R9";
    send(mk(4, 4, 0));
    run_stats(10, hi, rs);
    check("R9 ignored while disabled", hi, 0);

    // R1/R2: first load, period 10 duty 5 tick0
    en = 1'b1;
    cur_req = "R2";
    send(mk(10, 5, 0));
    check("R2 output high after first load", pwm, 1);
    cur_req = "R5";
    run_stats(40, hi, rs);
    check("R5 high count 5 of 10", hi, 20);
    check("R5 one pulse per period", rs, 4);

    // R3: new word mid-period, then wait for boundary
    cur_req = "R3";
    repeat (3) @(negedge clk);
    send(mk(8, 2, 1));
    run_stats(64, hi, rs);
    check("R3 period 8 at half rate", rs, 4);
    check("R1 duty field 2 of 8 ticks", hi, 16);

    // R6: duty zero, then duty above period
    cur_req = "R6";
    send(mk(6, 0, 0));
    repeat (20) @(negedge clk);
    run_stats(24, hi, rs);
    check("R6 duty 0 keeps low", hi, 0);
    send(mk(6, 20, 0));
    repeat (8) @(negedge clk);
    run_stats(24, hi, rs);
    check("R6 duty above period keeps high", hi, 24);

    // R8: out-of-range select falls back to tick 0
    cur_req = "R8";
    send(mk(4, 1, 9));
    repeat (8) @(negedge clk);
    run_stats(40, hi, rs);
    check("R8 fallback to tick0 rises", rs, 10);

    // R4: slow tick, period 3 duty 1 on 1/3 rate
    cur_req = "R4";
    send(mk(3, 1, 2));
    repeat (12) @(negedge clk);
    run_stats(45, hi, rs);
    check("R4 counter steps on selected tick only", hi, 15);

    // R7: stop with period 0, then restart while stopped
    cur_req = "R7";
    send(mk(0, 3, 0));
    repeat (12) @(negedge clk);
    run_stats(20, hi, rs);
    check("R7 period 0 output low", hi, 0);
    send(mk(5, 3, 0));
    repeat (2) @(negedge clk);
    run_stats(20, hi, rs);
    check("R7 restart after stop", hi, 12);

    // R3: back-to-back words before boundary, last wins; also boundary-cycle word
    cur_req = "R3";
    send(mk(40, 40, 3));
    repeat (6) @(negedge clk);
    send(mk(2, 0, 0));
    send(mk(4, 2, 0));
    repeat (200) @(negedge clk);
    run_stats(40, hi, rs);
    check("R3 last shadow word wins", hi, 20);
    check("R3 last shadow word period", rs, 10);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); vld = 1'b1; word = mk(4 + (k % 2), 1 + k % 3, k % 2);
    end
    @(negedge clk); vld = 1'b0; word = '0;
    repeat (30) @(negedge clk);

    // R9: disable mid-run, re-enable with first load
    cur_req = "R9";
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R9 low after disable", pwm, 0);
    send(mk(4, 4, 0));
    check("R9 still low with word while disabled", pwm, 0);
    en = 1'b1;
    cur_req = "R2";
    send(mk(7, 7, 0));
    check("R2 first load after re-enable", pwm, 1);
    run_stats(21, hi, rs);
    check("R2 full duty after re-enable", hi, 21);

    // R1: fields with high bits set
    cur_req = "R1";
    send(mk(3, 24'h800001, 1));
    repeat (10) @(negedge clk);
    run_stats(12, hi, rs);
    check("R1 wide duty field", hi, 12);

    finish_run();
  end
endmodule